// File: doc/BRIEF.md
# Per-Core Prescaled Interval Tick Timer Bank

This block holds a bank of identical tick timers, one for each processor core. Each timer has a 256-byte register window, and each drives its own interrupt line. A timer first divides the clock by a programmable prescale to make ticks. It then counts a programmable number of ticks and flags an interrupt when that count runs out. In interval mode the timer reloads its count and keeps firing until software stops it. In one-shot mode it fires once and then halts its own interrupt counter.

Software programs a timer through simple single-cycle register writes and reads. The block confirms each write to the prescale buffer, the count buffer and the control register through a write-status bit. That bit comes up a fixed number of cycles after the write is accepted, and software clears it by writing a 1 to it. The interrupt-pending flag clears the same way. An enable bit gates the pending flag onto the timer's interrupt output.

Top module: `core_tick_bank`

## Requirements
- R1: Timer n answers at addresses 0x300 + 0x100·n, with these offsets inside its window: prescale buffer 0x00, count buffer 0x08, control 0x20, interrupt status 0x30, interrupt enable 0x34, write status 0x40. Every other address, including any window at or beyond index N_TIMERS, reads as zero. Unused bits of the control register read as zero.
- R2: After reset every register of every timer reads zero and every interrupt line is low.
- R3: While control bits 0 and 1 are both set, the prescaler produces one tick every T+1 clock cycles, where T is the prescale buffer.
- R4: After a control write that sets bits 0 and 1, the pending flag rises exactly M·(T+1) cycles after the clock edge that accepted the write. M is the count buffer, and M = 0 behaves as M = 1.
- R5: A count-buffer write with bit 31 set loads bits 30:0 as the new count. A write with bit 31 clear leaves the buffer unchanged. Bit 31 always reads as zero.
- R6: With control bit 2 clear (one-shot mode), expiry clears control bit 1 by itself, and no further pending flag follows.
- R7: With control bit 2 set (interval mode), the count reloads on expiry and pending rises again every M·(T+1) cycles. The control register keeps its value.
- R8: Pending stays set until software writes 1 to status bit 0. If an expiry and that clear fall in the same cycle, pending stays set.
- R9: Each interrupt line equals its timer's pending flag ANDed with enable bit 0.
- R10: Clearing control bit 0 or bit 1 halts counting. A later restart counts a full M·(T+1) cycles from the buffered values.
- R11: Write-status bit 0 (prescale buffer), bit 1 (count buffer) and bit 3 (control) each set WS_LAT cycles after the write that they confirm. Each clears when software writes 1 to it. Writes to any other register set none of these bits.
- R12: A write to one timer's window changes nothing in any other timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, accepted on the rising edge |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | N_TIMERS | One interrupt line per timer |

## Verification
A wrong prescale or count state shows up as an interrupt that rises early or late. The bench measures the delay from the control write to the rise to the exact cycle, over a sweep of prescale and count values, so any off-by-one error shows within that first period. A run bit or reload that fails to update shows within the next period: either a second interrupt appears in one-shot mode, or the second interrupt is missing in interval mode, and a control read taken right after expiry also exposes it. A write-status error shows within WS_LAT cycles of the write, because the bench reads the status word on each cycle that follows.

// File: rtl/core_tick_pkg.sv
package core_tick_pkg;

    localparam int WIN_BASE  = 'h300;
    localparam int WIN_SHIFT = 8;

    localparam logic [7:0] OFS_TICKBUF = 8'h00;
    localparam logic [7:0] OFS_ICNTBUF = 8'h08;
    localparam logic [7:0] OFS_CTRL    = 8'h20;
    localparam logic [7:0] OFS_ISTAT   = 8'h30;
    localparam logic [7:0] OFS_IEN     = 8'h34;
    localparam logic [7:0] OFS_WSTAT   = 8'h40;

    // control bit positions
    localparam int CTL_TICK_RUN = 0;
    localparam int CTL_CNT_RUN  = 1;
    localparam int CTL_INTERVAL = 2;

    // count-buffer update request flag
    localparam int UPD_BIT = 31;

    // number of registers confirmed through write status
    localparam int N_WS = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TICKBUF,
        SEL_ICNTBUF,
        SEL_CTRL,
        SEL_ISTAT,
        SEL_IEN,
        SEL_WSTAT
    } reg_sel_e;

    // status bit position of each confirmed register: prescale, count, control
    function automatic int ws_pos(input int g);
        return (g == 2) ? 3 : g;
    endfunction

endpackage

// File: rtl/tick_addr_decode.sv
module tick_addr_decode
    import core_tick_pkg::*;
#(
    parameter int N_TIMERS = 4,
    parameter int ADDR_W   = 12,
    localparam int IDX_W   = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output reg_sel_e          sel
);

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] win;
    logic              in_bank;

    always_comb begin
        rel     = addr - ADDR_W'(WIN_BASE);
        win     = rel >> WIN_SHIFT;
        in_bank = (addr >= ADDR_W'(WIN_BASE)) && (win < ADDR_W'(N_TIMERS));
        idx     = win[IDX_W-1:0];
        case (rel[7:0])
            OFS_TICKBUF: sel = SEL_TICKBUF;
            OFS_ICNTBUF: sel = SEL_ICNTBUF;
            OFS_CTRL:    sel = SEL_CTRL;
            OFS_ISTAT:   sel = SEL_ISTAT;
            OFS_IEN:     sel = SEL_IEN;
            OFS_WSTAT:   sel = SEL_WSTAT;
            default:     sel = SEL_NONE;
        endcase
        hit = in_bank && (sel != SEL_NONE);
    end

endmodule

// File: rtl/tick_wstat_track.sv
module tick_wstat_track #(
    parameter int WS_LAT = 2,
    localparam int CW    = $clog2(WS_LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic clr,
    output logic flag
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } ws_state_t;

    ws_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.flag = 1'b0;
        end
        if (start) begin
            // a new write restarts the confirmation delay
            st_d.cnt = CW'(WS_LAT);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core
    import core_tick_pkg::*;
#(
    parameter int TICK_W = 32,
    parameter int ICNT_W = 31,
    parameter int WS_LAT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  reg_sel_e    wr_sel,
    input  logic [31:0] wr_data,
    input  reg_sel_e    rd_sel,
    output logic [31:0] rd_data,
    output logic        irq
);

    typedef struct packed {
        logic [TICK_W-1:0] tick_buf;
        logic [ICNT_W-1:0] icnt_buf;
        logic [2:0]        ctrl;
        logic              pend;
        logic              ien;
        logic [TICK_W-1:0] pre_cnt;
        logic [ICNT_W-1:0] icnt_cur;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    logic            run;
    logic            tick;
    logic            expire;
    logic [N_WS-1:0] ws_start;
    logic [N_WS-1:0] ws_clr;
    logic [N_WS-1:0] ws_flag;
    logic [31:0]     ws_word;

    // write confirmation trackers, one per confirmed register
    for (genvar g = 0; g < N_WS; g++) begin : g_ws
        localparam int POS = ws_pos(g);
        assign ws_clr[g] = wr_en && (wr_sel == SEL_WSTAT) && wr_data[POS];
        tick_wstat_track #(.WS_LAT(WS_LAT)) u_track (
            .clk   (clk),
            .rst_n (rst_n),
            .start (ws_start[g]),
            .clr   (ws_clr[g]),
            .flag  (ws_flag[g])
        );
    end

    always_comb begin
        ws_start[0] = wr_en && (wr_sel == SEL_TICKBUF);
        ws_start[1] = wr_en && (wr_sel == SEL_ICNTBUF);
        ws_start[2] = wr_en && (wr_sel == SEL_CTRL);
        ws_word     = '0;
        for (int g = 0; g < N_WS; g++) begin
            ws_word[ws_pos(g)] = ws_flag[g];
        end
    end

    // next-state logic
    always_comb begin
        st_d   = st_q;
        run    = st_q.ctrl[CTL_TICK_RUN] && st_q.ctrl[CTL_CNT_RUN];
        tick   = run && (st_q.pre_cnt >= st_q.tick_buf);
        expire = 1'b0;

        // prescaler: held at zero while stopped
        if (!run) begin
            st_d.pre_cnt = '0;
        end else if (tick) begin
            st_d.pre_cnt = '0;
        end else begin
            st_d.pre_cnt = st_q.pre_cnt + 1'b1;
        end

        // interrupt counter: counts down to one, then expires
        if (!run) begin
            st_d.icnt_cur = st_q.icnt_buf;
        end else if (tick) begin
            if (st_q.icnt_cur <= ICNT_W'(1)) begin
                expire        = 1'b1;
                st_d.icnt_cur = st_q.icnt_buf;
                if (!st_q.ctrl[CTL_INTERVAL]) begin
                    st_d.ctrl[CTL_CNT_RUN] = 1'b0;
                end
            end else begin
                st_d.icnt_cur = st_q.icnt_cur - 1'b1;
            end
        end

        // register writes
        if (wr_en) begin
            case (wr_sel)
                SEL_TICKBUF: st_d.tick_buf = wr_data[TICK_W-1:0];
                SEL_ICNTBUF: begin
                    if (wr_data[UPD_BIT]) begin
                        st_d.icnt_buf = wr_data[ICNT_W-1:0];
                    end
                end
                SEL_CTRL:    st_d.ctrl = wr_data[2:0];
                SEL_ISTAT: begin
                    if (wr_data[0]) begin
                        st_d.pend = 1'b0;
                    end
                end
                SEL_IEN:     st_d.ien = wr_data[0];
                default:     ;
            endcase
        end

        // an expiry beats a clear in the same cycle
        if (expire) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_TICKBUF: rd_data[TICK_W-1:0] = st_q.tick_buf;
            SEL_ICNTBUF: rd_data[ICNT_W-1:0] = st_q.icnt_buf;
            SEL_CTRL:    rd_data[2:0]        = st_q.ctrl;
            SEL_ISTAT:   rd_data[0]          = st_q.pend;
            SEL_IEN:     rd_data[0]          = st_q.ien;
            SEL_WSTAT:   rd_data             = ws_word;
            default:     rd_data             = '0;
        endcase
    end

    assign irq = st_q.pend && st_q.ien;

endmodule

// File: rtl/core_tick_bank.sv
module core_tick_bank
    import core_tick_pkg::*;
#(
    parameter int N_TIMERS = 4,
    parameter int ADDR_W   = 12,
    parameter int TICK_W   = 32,
    parameter int ICNT_W   = 31,
    parameter int WS_LAT   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [31:0]         wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [31:0]         rd_data,
    output logic [N_TIMERS-1:0] irq
);

    localparam int IDX_W = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1;

    logic             wr_hit, rd_hit;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    reg_sel_e         wr_sel, rd_sel;
    logic [31:0]      rd_word [N_TIMERS];

    tick_addr_decode #(.N_TIMERS(N_TIMERS), .ADDR_W(ADDR_W)) u_wr_dec (
        .addr (wr_addr),
        .hit  (wr_hit),
        .idx  (wr_idx),
        .sel  (wr_sel)
    );

    tick_addr_decode #(.N_TIMERS(N_TIMERS), .ADDR_W(ADDR_W)) u_rd_dec (
        .addr (rd_addr),
        .hit  (rd_hit),
        .idx  (rd_idx),
        .sel  (rd_sel)
    );

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
        logic tmr_wr;
        assign tmr_wr = wr_en && wr_hit && (wr_idx == IDX_W'(i));
        tick_timer_core #(
            .TICK_W (TICK_W),
            .ICNT_W (ICNT_W),
            .WS_LAT (WS_LAT)
        ) u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (tmr_wr),
            .wr_sel  (wr_sel),
            .wr_data (wr_data),
            .rd_sel  (rd_sel),
            .rd_data (rd_word[i]),
            .irq     (irq[i])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_TIMERS; i++) begin
            if (rd_hit && (rd_idx == IDX_W'(i))) begin
                rd_data = rd_word[i];
            end
        end
    end

endmodule

// File: rtl/core_tick_bank_chk.sv
module core_tick_bank_chk #(
    parameter int N_TIMERS = 4,
    parameter int ADDR_W   = 12,
    parameter int WS_LAT   = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [31:0]         wr_data,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [31:0]         rd_data,
    input logic [N_TIMERS-1:0] irq
);

    localparam logic [ADDR_W-1:0] BANK_BASE = ADDR_W'('h300);

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr < BANK_BASE) |-> (rd_data == 32'h0)); // R1

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_t
        localparam logic [ADDR_W-1:0] B = BANK_BASE + ADDR_W'(i * 256);
        logic in_win;
        assign in_win = wr_en && (wr_addr >= B) && (wr_addr <= B + ADDR_W'(255));

        AST_ICNT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr == B + ADDR_W'('h08)) |-> !rd_data[31]); // R5

        AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr == B + ADDR_W'('h20)) |-> (rd_data[31:3] == '0)); // R1

        AST_IEN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_addr == B + ADDR_W'('h34)) && !wr_data[0]) |=> !irq[i]); // R9

        AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[i]) |-> $past(in_win)); // R8

        if (WS_LAT >= 2) begin : g_lat
            AST_WSTAT_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (wr_addr == B) && (rd_addr == B + ADDR_W'('h40)) && !rd_data[0])
                |=> ((rd_addr != B + ADDR_W'('h40)) || !rd_data[0])); // R11
        end
    end

endmodule

bind core_tick_bank core_tick_bank_chk #(
    .N_TIMERS (N_TIMERS),
    .ADDR_W   (ADDR_W),
    .WS_LAT   (WS_LAT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq     (irq)
);

// File: tb/core_tick_bank_tb.sv
module core_tick_bank_tb;

    localparam int NT = 4;

    localparam logic [7:0] O_TB = 8'h00;
    localparam logic [7:0] O_CB = 8'h08;
    localparam logic [7:0] O_CT = 8'h20;
    localparam logic [7:0] O_IS = 8'h30;
    localparam logic [7:0] O_IE = 8'h34;
    localparam logic [7:0] O_WS = 8'h40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [11:0]   wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [11:0]   rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NT-1:0] irq;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    core_tick_bank u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq     (irq)
    );

    function automatic logic [11:0] ra(input int t, input logic [7:0] ofs);
        return 12'(12'h300 + t * 256 + int'(ofs));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_irq(input int t, input int limit, output int cnt);
        cnt = 0;
        while (cnt < limit && !irq[t]) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    initial begin
        logic [31:0] v;
        int          cnt;
        logic [7:0]  ofs [6];
        ofs = '{O_TB, O_CB, O_CT, O_IS, O_IE, O_WS};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        check("R2 irq", 32'(irq), 32'h0);
        for (int t = 0; t < NT; t++) begin
            for (int k = 0; k < 6; k++) begin
                rd(ra(t, ofs[k]), v);
                check("R2 register", v, 32'h0);
            end
        end

        // R1: address map and unmapped reads
        wr(ra(2, O_TB), 32'h0000_1234);
        rd(ra(2, O_TB), v);           check("R1 readback", v, 32'h0000_1234);
        rd(12'h100, v);               check("R1 below bank", v, 32'h0);
        rd(ra(NT, O_TB), v);          check("R1 beyond N", v, 32'h0);
        rd(ra(2, 8'h10), v);          check("R1 hole", v, 32'h0);
        rd(ra(1, O_TB), v);           check("R12 neighbour", v, 32'h0);

        // R5: count buffer update flag
        wr(ra(3, O_CB), 32'h0000_0005);
        rd(ra(3, O_CB), v);           check("R5 no flag", v, 32'h0);
        wr(ra(3, O_CB), 32'h8000_0005);
        rd(ra(3, O_CB), v);           check("R5 load", v, 32'h5);
        wr(ra(3, O_CB), 32'h0000_0009);
        rd(ra(3, O_CB), v);           check("R5 ignored", v, 32'h5);
        wr(ra(3, O_CB), 32'hFFFF_FFFF);
        rd(ra(3, O_CB), v);           check("R5 top bit", v, 32'h7FFF_FFFF);

        // R11: write status latency and clearing on timer 1
        wr(ra(1, O_TB), 32'h7);
        rd(ra(1, O_WS), v);           check("R11 k0", v, 32'h0);
        @(negedge clk);
        rd(ra(1, O_WS), v);           check("R11 k1", v, 32'h0);
        @(negedge clk);
        rd(ra(1, O_WS), v);           check("R11 k2", v, 32'h1);
        wr(ra(1, O_WS), 32'h1);
        rd(ra(1, O_WS), v);           check("R11 clear", v, 32'h0);
        wr(ra(1, O_CB), 32'h8000_0001);
        repeat (3) @(negedge clk);
        rd(ra(1, O_WS), v);           check("R11 count", v, 32'h2);
        wr(ra(1, O_CT), 32'h0);
        repeat (3) @(negedge clk);
        rd(ra(1, O_WS), v);           check("R11 ctrl", v, 32'hA);
        wr(ra(1, O_WS), 32'hA);
        rd(ra(1, O_WS), v);           check("R11 clear both", v, 32'h0);
        wr(ra(1, O_IE), 32'h0);
        repeat (3) @(negedge clk);
        rd(ra(1, O_WS), v);           check("R11 other reg", v, 32'h0);

        // R3 R4 R6: one-shot sweep over prescale and count on timer 0
        wr(ra(0, O_IE), 32'h1);
        for (int t = 0; t < 4; t++) begin
            for (int m = 0; m < 4; m++) begin
                int p;
                p = ((m == 0) ? 1 : m) * (t + 1);
                wr(ra(0, O_CT), 32'h0);
                wr(ra(0, O_TB), 32'(t));
                wr(ra(0, O_CB), 32'h8000_0000 | 32'(m));
                wr(ra(0, O_IS), 32'h1);
                wr(ra(0, O_CT), 32'h3);
                wait_irq(0, 64, cnt);
                check("R3 R4 expiry cycles", 32'(cnt), 32'(p));
                check("R12 other lines", 32'(irq[NT-1:1]), 32'h0);
                rd(ra(0, O_CT), v);
                check("R6 run bit cleared", v, 32'h1);
                wr(ra(0, O_IS), 32'h1);
                repeat (2 * p + 4) @(negedge clk);
                check("R6 no refire", 32'(irq[0]), 32'h0);
            end
        end

        // R7: interval mode reload
        wr(ra(0, O_CT), 32'h0);
        wr(ra(0, O_TB), 32'h2);
        wr(ra(0, O_CB), 32'h8000_0003);
        wr(ra(0, O_IS), 32'h1);
        wr(ra(0, O_CT), 32'h7);
        wait_irq(0, 64, cnt);
        check("R7 first", 32'(cnt), 32'd9);
        wr(ra(0, O_IS), 32'h1);
        wait_irq(0, 64, cnt);
        check("R7 second", 32'(cnt), 32'd7);
        rd(ra(0, O_CT), v);
        check("R7 ctrl kept", v, 32'h7);

        // R8 R9: set beats clear, enable gating
        wr(ra(0, O_CT), 32'h0);
        wr(ra(0, O_TB), 32'h0);
        wr(ra(0, O_CB), 32'h8000_0001);
        wr(ra(0, O_IS), 32'h1);
        wr(ra(0, O_CT), 32'h7);
        @(negedge clk);
        check("R8 pending up", 32'(irq[0]), 32'h1);
        wr(ra(0, O_IS), 32'h1);
        check("R8 set wins", 32'(irq[0]), 32'h1);
        wr(ra(0, O_IE), 32'h0);
        check("R9 gated off", 32'(irq[0]), 32'h0);
        rd(ra(0, O_IS), v);
        check("R9 pending kept", v, 32'h1);
        wr(ra(0, O_IE), 32'h1);
        check("R9 gated on", 32'(irq[0]), 32'h1);
        check("R12 timer1 quiet", 32'(irq[1]), 32'h0);
        wr(ra(0, O_CT), 32'h0);
        wr(ra(0, O_IS), 32'h1);
        check("R8 cleared", 32'(irq[0]), 32'h0);

        // R10: halt and restart from buffered values
        wr(ra(0, O_TB), 32'h3);
        wr(ra(0, O_CB), 32'h8000_0004);
        wr(ra(0, O_CT), 32'h3);
        repeat (9) @(negedge clk);
        wr(ra(0, O_CT), 32'h0);
        repeat (40) @(negedge clk);
        check("R10 halted", 32'(irq[0]), 32'h0);
        wr(ra(0, O_CT), 32'h3);
        wait_irq(0, 64, cnt);
        check("R10 full period", 32'(cnt), 32'd16);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule